// File: doc/BRIEF.md
# Freezable Pseudo-Random Backoff Generator

This block produces a pseudo-random number for a collision backoff calculation on a shared medium. An 8-bit linear feedback shift register with XNOR feedback steps once on every clock in which the tick enable is high. Software never has to service it. With XNOR feedback the all-zeros state is an ordinary member of the sequence, so the register comes out of reset at zero and runs from there. The all-ones state is the single state that maps onto itself.

Software can write the register. Writing all ones parks the generator at all ones, and it stays there until some other value is written. Any other value becomes the new state, and stepping continues from it. A capture strobe copies the present value into a separate seed register for the backoff logic. The live value keeps moving after a capture, so a later read of the generator generally differs from the seed that was taken.

Top module: `backoff_prng`

## Requirements
- R1: Synchronous active-low reset clears both the generator state (`rd_data`) and the captured seed (`seed_out`) to all zeros.
- R2: When `tick_en` is high and `wr_en` is low, the state advances on each rising clock edge as follows. The state shifts left by one bit, and the new bit 0 is the XNOR of old bits 7, 5, 4 and 3. For example, from 8'h00 the state steps to 8'h01.
- R3: When `tick_en` and `wr_en` are both low, the state holds its value.
- R4: A write (`wr_en` high) of any value other than 8'hFF loads that value in the next cycle. Stepping per R2 then resumes from the loaded value.
- R5: After a write of 8'hFF, the state stays at 8'hFF even with `tick_en` high, until another value is written.
- R6: When `wr_en` and `tick_en` are both high in the same cycle, the written value is loaded and the shift step is not taken.
- R7: When `seed_cap` is high, `seed_out` takes the value `rd_data` had before that edge. When `seed_cap` is low, `seed_out` holds its value.
- R8: After a capture, `rd_data` keeps advancing while `seed_out` holds the captured value.
- R9: Starting from all zeros with continuous ticks, the state first returns to all zeros after exactly 255 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Step enable for the generator |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Value to write |
| seed_cap | input | 1 | Strobe that copies the live value into the seed register |
| rd_data | output | 8 | Live generator value |
| seed_out | output | 8 | Last captured seed |

## Verification
The bench builds the block with its default parameters: an 8-bit width and feedback from bits 7, 5, 4 and 3. At that size the complete 255-state cycle fits inside a short run, so R9 can be checked from end to end. The same size also reaches the lock-up state at all ones by an explicit write. A behavioural model runs alongside the design and is compared on every clock.

// File: rtl/backoff_prng_pkg.sv
// Package backoff_prng_pkg
// Purpose : shared width and the feedback function used by the generator.
// Assumes : the tap mask selects a maximal-length XNOR set for the width.
package backoff_prng_pkg;

    localparam int unsigned PRNG_W = 8;

    typedef logic [PRNG_W-1:0] prng_word_t;

    // Compute the XNOR feedback bit of the masked state bits.
    function automatic logic xnor_feedback(input logic [PRNG_W-1:0] state,
                                           input logic [PRNG_W-1:0] mask);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < PRNG_W; i++) begin
            if (mask[i]) acc = acc ^ state[i];
        end
        return ~acc;
    endfunction

endpackage

// File: rtl/prng_shift_core.sv
// Module prng_shift_core
// Purpose : holds the generator state, steps it with XNOR feedback,
//           and accepts software loads with priority over a step.
// Assumes : all ones is the sole self-mapping state, so a written
//           all-ones value is held without any extra logic.
module prng_shift_core
    import backoff_prng_pkg::*;
#(
    parameter logic [PRNG_W-1:0] TAP_MASK = 8'hB8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load_en,
    input  logic [PRNG_W-1:0] load_val,
    output logic [PRNG_W-1:0] state_q
);

    localparam logic [PRNG_W-1:0] ALL_ONES = '1;

    logic              fb_bit;
    logic [PRNG_W-1:0] shifted;

    // Form the stepped value from the present state.
    always_comb begin
        fb_bit  = xnor_feedback(state_q, TAP_MASK);
        shifted = {state_q[PRNG_W-2:0], fb_bit};
    end

    // State register: reset, then load, then step, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= '0;
        else if (load_en) state_q <= load_val;
        else if (step_en) state_q <= shifted;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(state_q));

    a_r5_frozen_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ALL_ONES && !load_en) |=> state_q == ALL_ONES);

    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> state_q == $past(load_val));

endmodule

// File: rtl/seed_latch.sv
// Module seed_latch
// Purpose : keeps a copy of the generator value taken on a capture strobe.
// Assumes : the source value is the registered state before the edge.
module seed_latch
    import backoff_prng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [PRNG_W-1:0] src,
    output logic [PRNG_W-1:0] seed_q
);

    // Seed register: take the source on a strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      seed_q <= '0;
        else if (cap_en) seed_q <= src;
    end

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> seed_q == $past(src));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(seed_q));

endmodule

// File: rtl/backoff_prng.sv
// Module backoff_prng
// Purpose : top of the backoff number generator. It joins the stepping
//           core and the seed capture register.
// Assumes : writes and captures are single-cycle strobes in the clk domain.
module backoff_prng
    import backoff_prng_pkg::*;
#(
    parameter logic [PRNG_W-1:0] TAP_MASK = 8'hB8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [PRNG_W-1:0] wr_data,
    input  logic              seed_cap,
    output logic [PRNG_W-1:0] rd_data,
    output logic [PRNG_W-1:0] seed_out
);

    logic [PRNG_W-1:0] live_val;

    prng_shift_core #(.TAP_MASK(TAP_MASK)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (tick_en),
        .load_en  (wr_en),
        .load_val (wr_data),
        .state_q  (live_val)
    );

    seed_latch u_seed (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (seed_cap),
        .src    (live_val),
        .seed_q (seed_out)
    );

    // Drive the read port from the live state.
    always_comb rd_data = live_val;

endmodule

// File: tb/backoff_prng_bench.sv
module backoff_prng_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       seed_cap = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] seed_out;

    int   n_checks = 0;
    int   n_fail = 0;
    int   m_state = 0;
    int   m_seed = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    backoff_prng u_backoff_prng (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_data(wr_data), .seed_cap(seed_cap),
        .rd_data(rd_data), .seed_out(seed_out)
    );

    // Model step per R2: shift left, new bit 0 = XNOR of bits 7,5,4,3.
    function automatic int model_next(input int s);
        int b;
        b = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        return ((s << 1) & 8'hFE) | (b ^ 1);
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp_v);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare after.
    task automatic cyc(input string req, input bit te, input bit we,
                       input int wd, input bit cap);
        @(negedge clk);
        tick_en = te; wr_en = we; wr_data = wd[7:0]; seed_cap = cap;
        @(posedge clk);
        if (!rst_n) begin
            m_state = 0; m_seed = 0;
        end else begin
            if (cap) m_seed = m_state;
            if (we) m_state = wd & 8'hFF;
            else if (te) m_state = model_next(m_state);
        end
        @(negedge clk);
        check(req, int'(rd_data), m_state);
        check(req, int'(seed_out), m_seed);
        tick_en = 1'b0; wr_en = 1'b0; seed_cap = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int first_zero;
        // R1: reset state
        rst_n = 1'b0;
        cyc("R1", 1'b1, 1'b0, 0, 1'b1);
        cyc("R1", 1'b0, 1'b1, 8'h5A, 1'b0);
        rst_n = 1'b1;
        cyc("R1", 1'b0, 1'b0, 0, 1'b0);
        // R2: step from zero must give 01 first
        cyc("R2", 1'b1, 1'b0, 0, 1'b0);
        check("R2", int'(rd_data), 8'h01);
        for (int i = 0; i < 20; i++) cyc("R2", 1'b1, 1'b0, 0, 1'b0);
        // R3: idle holds
        for (int i = 0; i < 5; i++) cyc("R3", 1'b0, 1'b0, 0, 1'b0);
        // R4: load then resume
        cyc("R4", 1'b0, 1'b1, 8'hA7, 1'b0);
        check("R4", int'(rd_data), 8'hA7);
        for (int i = 0; i < 10; i++) cyc("R4", 1'b1, 1'b0, 0, 1'b0);
        // R5: freeze at all ones
        cyc("R5", 1'b1, 1'b1, 8'hFF, 1'b0);
        for (int i = 0; i < 12; i++) cyc("R5", 1'b1, 1'b0, 0, 1'b0);
        check("R5", int'(rd_data), 8'hFF);
        cyc("R5", 1'b1, 1'b1, 8'h3C, 1'b0);
        cyc("R5", 1'b1, 1'b0, 0, 1'b0);
        check("R5", int'(rd_data), model_next(8'h3C));
        // R6: write and tick in the same cycle
        cyc("R6", 1'b1, 1'b1, 8'h81, 1'b0);
        check("R6", int'(rd_data), 8'h81);
        // R7/R8: capture then keep stepping
        cyc("R7", 1'b1, 1'b0, 0, 1'b1);
        check("R7", int'(seed_out), 8'h81);
        for (int i = 0; i < 6; i++) cyc("R8", 1'b1, 1'b0, 0, 1'b0);
        check("R8", int'(seed_out), 8'h81);
        check("R8", int'(rd_data != seed_out), 1);
        cyc("R7", 1'b0, 1'b1, 8'h11, 1'b1);
        // R9: period 255 from zero
        rst_n = 1'b0;
        cyc("R9", 1'b0, 1'b0, 0, 1'b0);
        rst_n = 1'b1;
        first_zero = 0;
        for (int i = 1; i <= 255; i++) begin
            cyc("R9", 1'b1, 1'b0, 0, 1'b0);
            if (rd_data == 8'h00 && first_zero == 0) first_zero = i;
        end
        check("R9", first_zero, 255);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule